// File: doc/BRIEF.md
# Exception Entry State-Save Controller

This block performs exception entry for a 32-bit RISC core. It handles two exception types: trace (single-step) and floating-point assist. On the clock edge that takes an exception it does four things. It loads the resume address into save register 0 (`srr0`). It copies the low half of the machine state word into save register 1 (`srr1`). It produces the machine state word to be used after entry (`msr_wdata`). It pulses a redirect strobe that carries the vector fetch address.

There is one case that looks like a floating-point assist but is not. If the enabled floating-point condition is created by a state-write instruction (a write to the FP status register, a write to the machine state, or a return from interrupt), the block raises a program-exception request instead. That request is handled elsewhere.

Control is a two-state machine. `ST_IDLE` waits for an event. On the edge that takes an entry, the transition `IDLE->ENTRY` loads all the save outputs and the redirect. The transition `ENTRY->IDLE` follows unconditionally one cycle later. While the machine is in `ST_ENTRY`, incoming events are discarded, because the pipeline is being flushed. A program request leaves the machine in `ST_IDLE` (transition `IDLE->IDLE`).

Field positions use little-endian bit indices (bit 0 is the LSB):

| Bit | Meaning |
|-----|---------|
| 0 | little-endian mode |
| 1 | recoverable |
| 3 | compression enable |
| 6 | vector prefix |
| 8 | FP enable 1 |
| 11 | FP enable 0 |
| 12 | machine-check enable |
| 16 | interrupt little-endian |

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, `redirect`, `prog_req`, `redirect_addr`, `srr0`, `srr1` and `msr_wdata` are all 0.
- R2: An FP assist entry is taken when `retire_fp`=1, (msr bit 11 OR msr bit 8)=1, `fex`=1 and `state_wr`=0. It vectors to base+0x0E00 and loads `srr0` with `cur_addr`. If both enables are 0, nothing happens.
- R3: `tiny_det`=1 with `ue`=0 also takes an FP assist entry. `tiny_det`=1 with `ue`=1 has no effect.
- R4: When the enabled FP condition of R2 holds with `state_wr`=1, `prog_req` pulses for one cycle and no redirect occurs.
- R5: `trace_req` takes a trace entry to base+0x0D00 and loads `srr0` with `next_addr`.
- R6: The base is 0x0000_0000 when msr bit 6 is 0, and 0xFFF0_0000 when it is 1.
- R7: On entry, `srr1[15:0]` takes `msr_in[15:0]` (so bit 1, the recoverable bit, is copied and not forced clear). `srr1[30:27]` and `srr1[21:16]` are cleared, and bits 31 and 26:22 keep their previous value.
- R8: On entry, `msr_wdata` bit 0 takes msr bit 16, and bits 12 and 6 keep their values. Bit 3 = `en_comp` AND `exc_comp`. Every other bit is 0.
- R9: When `cmp_mode`=1, `srr0` receives the compressed address (`cur_addr_cmp` for FP assist, `next_addr_cmp` for trace).
- R10: Priority is program request > FP assist > trace. Only one is acted on per edge, and the others in that cycle are discarded.
- R11: `redirect` lasts exactly one cycle, and `srr0`/`srr1`/`msr_wdata`/`redirect_addr` change on the same edge. Events present during the `ST_ENTRY` cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| retire_fp | input | 1 | An instruction that can raise the FP summary retired |
| state_wr | input | 1 | That instruction was a state-write (FP status, machine state, return) |
| tiny_det | input | 1 | Tiny result detected |
| trace_req | input | 1 | Single-step trace event |
| cur_addr | input | 32 | Address of the current instruction |
| next_addr | input | 32 | Address of the following instruction |
| cur_addr_cmp | input | 32 | Compressed form of `cur_addr` |
| next_addr_cmp | input | 32 | Compressed form of `next_addr` |
| cmp_mode | input | 1 | Fetch is in compression mode |
| msr_in | input | 32 | Current machine state word |
| fex | input | 1 | FP enabled-exception summary |
| ue | input | 1 | FP underflow enable |
| en_comp | input | 1 | Compression control: enable |
| exc_comp | input | 1 | Compression control: keep on during exceptions |
| redirect | output | 1 | One-cycle fetch redirect strobe |
| redirect_addr | output | 32 | Vector fetch address |
| prog_req | output | 1 | One-cycle program-exception request |
| srr0 | output | 32 | Save register 0 |
| srr1 | output | 32 | Save register 1 |
| msr_wdata | output | 32 | Machine state after entry |

## Verification
The assertions assume that each event input is a single-cycle request, and that it is driven clean of X once reset is released. They also assume that `msr_in` reflects the pre-entry state for the cycle in which an event is presented. The bench drives every input on the falling edge and holds it across exactly one rising edge. It then returns all event inputs to zero through the `ST_ENTRY` cycle, except in the one scenario that deliberately holds a trace request across that cycle to show it is dropped.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int XLEN = 32;

    localparam int B_LE   = 0;
    localparam int B_RI   = 1;
    localparam int B_DCMP = 3;
    localparam int B_IP   = 6;
    localparam int B_FE1  = 8;
    localparam int B_FE0  = 11;
    localparam int B_ME   = 12;
    localparam int B_ILE  = 16;

    localparam logic [XLEN-1:0] SRR1_KEEP = 32'h87C0_0000;
    localparam logic [XLEN-1:0] BASE_HI   = 32'hFFF0_0000;
    localparam logic [XLEN-1:0] OFS_TRACE = 32'h0000_0D00;
    localparam logic [XLEN-1:0] OFS_FPA   = 32'h0000_0E00;

    typedef enum logic [1:0] {
        EXC_NONE  = 2'd0,
        EXC_PROG  = 2'd1,
        EXC_FPA   = 2'd2,
        EXC_TRACE = 2'd3
    } exc_kind_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ENTRY = 1'b1
    } ent_state_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic      retire_fp,
    input  logic      state_wr,
    input  logic      tiny_det,
    input  logic      trace_req,
    input  logic      fe0,
    input  logic      fe1,
    input  logic      fex,
    input  logic      ue,
    output exc_kind_e kind
);
    logic fp_cond;
    logic want_prog;
    logic want_fpa;

    always_comb begin
        fp_cond   = retire_fp & (fe0 | fe1) & fex;
        want_prog = fp_cond & state_wr;
        want_fpa  = (fp_cond & ~state_wr) | (tiny_det & ~ue);
        if (want_prog)      kind = EXC_PROG;
        else if (want_fpa)  kind = EXC_FPA;
        else if (trace_req) kind = EXC_TRACE;
        else                kind = EXC_NONE;
    end
endmodule

// File: rtl/exc_save_calc.sv
module exc_save_calc
    import exc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  exc_kind_e      kind,
    input  logic [W-1:0]   cur_addr,
    input  logic [W-1:0]   next_addr,
    input  logic [W-1:0]   cur_addr_cmp,
    input  logic [W-1:0]   next_addr_cmp,
    input  logic           cmp_mode,
    input  logic [W-1:0]   msr_in,
    input  logic [W-1:0]   srr1_q,
    input  logic           en_comp,
    input  logic           exc_comp,
    output logic [W-1:0]   srr0_nxt,
    output logic [W-1:0]   srr1_nxt,
    output logic [W-1:0]   msr_nxt,
    output logic [W-1:0]   vec_nxt
);
    localparam int HALF = W / 2;

    logic [W-1:0] base;

    always_comb begin
        base = msr_in[B_IP] ? BASE_HI : '0;
        if (kind == EXC_TRACE) begin
            srr0_nxt = cmp_mode ? next_addr_cmp : next_addr;
            vec_nxt  = base | OFS_TRACE;
        end else begin
            srr0_nxt = cmp_mode ? cur_addr_cmp : cur_addr;
            vec_nxt  = base | OFS_FPA;
        end
        srr1_nxt = (srr1_q & SRR1_KEEP) | {{HALF{1'b0}}, msr_in[HALF-1:0]};
        msr_nxt          = '0;
        msr_nxt[B_LE]    = msr_in[B_ILE];
        msr_nxt[B_ME]    = msr_in[B_ME];
        msr_nxt[B_IP]    = msr_in[B_IP];
        msr_nxt[B_DCMP]  = en_comp & exc_comp;
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        retire_fp,
    input  logic        state_wr,
    input  logic        tiny_det,
    input  logic        trace_req,
    input  logic [31:0] cur_addr,
    input  logic [31:0] next_addr,
    input  logic [31:0] cur_addr_cmp,
    input  logic [31:0] next_addr_cmp,
    input  logic        cmp_mode,
    input  logic [31:0] msr_in,
    input  logic        fex,
    input  logic        ue,
    input  logic        en_comp,
    input  logic        exc_comp,
    output logic        redirect,
    output logic [31:0] redirect_addr,
    output logic        prog_req,
    output logic [31:0] srr0,
    output logic [31:0] srr1,
    output logic [31:0] msr_wdata
);
    ent_state_e   state_q, state_d;
    exc_kind_e    kind;
    logic [31:0]  srr0_nxt, srr1_nxt, msr_nxt, vec_nxt;
    logic         take_entry, take_prog;

    exc_arbiter u_arb (
        .retire_fp (retire_fp),
        .state_wr  (state_wr),
        .tiny_det  (tiny_det),
        .trace_req (trace_req),
        .fe0       (msr_in[B_FE0]),
        .fe1       (msr_in[B_FE1]),
        .fex       (fex),
        .ue        (ue),
        .kind      (kind)
    );

    exc_save_calc #(.W(XLEN)) u_calc (
        .kind          (kind),
        .cur_addr      (cur_addr),
        .next_addr     (next_addr),
        .cur_addr_cmp  (cur_addr_cmp),
        .next_addr_cmp (next_addr_cmp),
        .cmp_mode      (cmp_mode),
        .msr_in        (msr_in),
        .srr1_q        (srr1),
        .en_comp       (en_comp),
        .exc_comp      (exc_comp),
        .srr0_nxt      (srr0_nxt),
        .srr1_nxt      (srr1_nxt),
        .msr_nxt       (msr_nxt),
        .vec_nxt       (vec_nxt)
    );

    always_comb begin
        take_entry = 1'b0;
        take_prog  = 1'b0;
        state_d    = state_q;
        unique case (state_q)
            ST_IDLE: begin
                take_prog  = (kind == EXC_PROG);
                take_entry = (kind == EXC_FPA) || (kind == EXC_TRACE);
                if (take_entry) state_d = ST_ENTRY;
            end
            ST_ENTRY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            redirect      <= 1'b0;
            redirect_addr <= '0;
            prog_req      <= 1'b0;
            srr0          <= '0;
            srr1          <= '0;
            msr_wdata     <= '0;
        end else begin
            redirect <= take_entry;
            prog_req <= take_prog;
            if (take_entry) begin
                redirect_addr <= vec_nxt;
                srr0          <= srr0_nxt;
                srr1          <= srr1_nxt;
                msr_wdata     <= msr_nxt;
            end
        end
    end

    // R11: redirect is a single-cycle strobe
    p_redirect_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !redirect);
    // R4: a program request never coincides with a redirect
    p_prog_no_redirect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> !redirect);
    // R7: cleared save-register fields stay zero
    p_srr1_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (srr1[30:27] == 4'h0) && (srr1[21:16] == 6'h0));
    // R8: only the kept bits can be set in the entry machine state
    p_msr_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> ((msr_wdata & ~32'h0000_1049) == 32'h0));
    // R6: vector is one of the two bases plus a small offset
    p_vec_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> ((redirect_addr[31:20] == 12'h000) || (redirect_addr[31:20] == 12'hFFF))
                     && (redirect_addr[19:12] == 8'h00) && (redirect_addr[7:0] == 8'h00));
    // R2/R5: offset is either the trace or the FP assist slot
    p_vec_ofs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (redirect_addr[11:8] == 4'hD) || (redirect_addr[11:8] == 4'hE));
    // R11: machine leaves ENTRY after one cycle
    p_entry_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ENTRY) |=> (state_q == ST_IDLE));
endmodule

// File: tb/tb_exc_entry_ctrl.sv
`timescale 1ns/1ps
module tb_exc_entry_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retire_fp = 0, state_wr = 0, tiny_det = 0, trace_req = 0;
    logic [31:0] cur_addr = 0, next_addr = 0, cur_addr_cmp = 0, next_addr_cmp = 0;
    logic        cmp_mode = 0;
    logic [31:0] msr_in = 0;
    logic        fex = 0, ue = 0, en_comp = 0, exc_comp = 0;
    logic        redirect, prog_req;
    logic [31:0] redirect_addr, srr0, srr1, msr_wdata;

    int checks = 0;
    int failures = 0;
    logic [31:0] prev_srr1 = 0;

    always #4 clk = ~clk;

    exc_entry_ctrl dut (
        .clk(clk), .rst_n(rst_n), .retire_fp(retire_fp), .state_wr(state_wr),
        .tiny_det(tiny_det), .trace_req(trace_req), .cur_addr(cur_addr),
        .next_addr(next_addr), .cur_addr_cmp(cur_addr_cmp), .next_addr_cmp(next_addr_cmp),
        .cmp_mode(cmp_mode), .msr_in(msr_in), .fex(fex), .ue(ue), .en_comp(en_comp),
        .exc_comp(exc_comp), .redirect(redirect), .redirect_addr(redirect_addr),
        .prog_req(prog_req), .srr0(srr0), .srr1(srr1), .msr_wdata(msr_wdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_msr(input logic [31:0] m, input logic ec, input logic xc);
        logic [31:0] r = 32'h0;
        r[0] = m[16]; r[12] = m[12]; r[6] = m[6]; r[3] = ec & xc;
        return r;
    endfunction

    task automatic edge_and_settle();
        @(posedge clk); #1;
    endtask

    task automatic clear_events();
        @(negedge clk);
        retire_fp = 0; state_wr = 0; tiny_det = 0; trace_req = 0;
        edge_and_settle();
    endtask

    task automatic t_reset();
        chk("R1 redirect", {31'h0, redirect}, 32'h0);
        chk("R1 prog_req", {31'h0, prog_req}, 32'h0);
        chk("R1 srr0", srr0, 32'h0);
        chk("R1 srr1", srr1, 32'h0);
        chk("R1 msr_wdata", msr_wdata, 32'h0);
        chk("R1 redirect_addr", redirect_addr, 32'h0);
    endtask

    task automatic t_fpa();
        @(negedge clk);
        msr_in = 32'h0001_1803; fex = 1; retire_fp = 1;
        cur_addr = 32'h0000_4000; next_addr = 32'h0000_4004;
        en_comp = 1; exc_comp = 1;
        edge_and_settle();
        chk("R2 redirect", {31'h0, redirect}, 32'h1);
        chk("R2 vector", redirect_addr, 32'h0000_0E00);
        chk("R2 srr0", srr0, 32'h0000_4000);
        chk("R7 srr1", srr1, (prev_srr1 & 32'h87C0_0000) | 32'h0000_1803);
        chk("R8 msr", msr_wdata, exp_msr(msr_in, 1, 1));
        prev_srr1 = srr1;
        clear_events();
        chk("R11 one cycle", {31'h0, redirect}, 32'h0);
    endtask

    task automatic t_fpa_disabled();
        @(negedge clk);
        msr_in = 32'h0000_0000; fex = 1; retire_fp = 1;
        edge_and_settle();
        chk("R2 no enables", {31'h0, redirect}, 32'h0);
        chk("R2 no enables prog", {31'h0, prog_req}, 32'h0);
        clear_events();
    endtask

    task automatic t_tiny();
        @(negedge clk);
        msr_in = 32'h0000_0040; fex = 0; ue = 1; tiny_det = 1;
        edge_and_settle();
        chk("R3 tiny ue=1 ignored", {31'h0, redirect}, 32'h0);
        @(negedge clk); ue = 0; cur_addr = 32'h0000_8888;
        en_comp = 1; exc_comp = 0;
        edge_and_settle();
        chk("R3 tiny entry", {31'h0, redirect}, 32'h1);
        chk("R6 high base fpa", redirect_addr, 32'hFFF0_0E00);
        chk("R3 srr0", srr0, 32'h0000_8888);
        chk("R8 dcmp off", msr_wdata, exp_msr(msr_in, 1, 0));
        prev_srr1 = srr1;
        clear_events();
    endtask

    task automatic t_prog();
        logic [31:0] s0;
        s0 = srr0;
        @(negedge clk);
        msr_in = 32'h0000_0800; fex = 1; retire_fp = 1; state_wr = 1; trace_req = 1;
        cur_addr = 32'h0000_1230;
        edge_and_settle();
        chk("R4 prog_req", {31'h0, prog_req}, 32'h1);
        chk("R10 prog beats trace", {31'h0, redirect}, 32'h0);
        chk("R4 srr0 untouched", srr0, s0);
        clear_events();
        chk("R4 prog one cycle", {31'h0, prog_req}, 32'h0);
    endtask

    task automatic t_trace();
        @(negedge clk);
        msr_in = 32'h0000_0002; trace_req = 1; cmp_mode = 0;
        next_addr = 32'h0000_2224;
        edge_and_settle();
        chk("R5 vector", redirect_addr, 32'h0000_0D00);
        chk("R5 srr0", srr0, 32'h0000_2224);
        chk("R7 ri copied", srr1, (prev_srr1 & 32'h87C0_0000) | 32'h0000_0002);
        prev_srr1 = srr1;
        clear_events();
    endtask

    task automatic t_priority();
        @(negedge clk);
        msr_in = 32'h0000_0100; fex = 1; retire_fp = 1; trace_req = 1;
        cur_addr = 32'h0000_5000; next_addr = 32'h0000_5004;
        edge_and_settle();
        chk("R10 fpa beats trace", redirect_addr, 32'h0000_0E00);
        chk("R10 srr0", srr0, 32'h0000_5000);
        prev_srr1 = srr1;
        clear_events();
    endtask

    task automatic t_compress();
        @(negedge clk);
        msr_in = 32'h0000_0040; cmp_mode = 1; trace_req = 1;
        next_addr = 32'h0000_6004; next_addr_cmp = 32'h0003_0102;
        edge_and_settle();
        chk("R9 compressed srr0", srr0, 32'h0003_0102);
        chk("R6 high base trace", redirect_addr, 32'hFFF0_0D00);
        prev_srr1 = srr1;
        clear_events();
        cmp_mode = 0;
    endtask

    task automatic t_hold();
        logic [31:0] s0;
        @(negedge clk);
        msr_in = 32'h0000_0000; trace_req = 1; next_addr = 32'h0000_7000;
        edge_and_settle();
        chk("R11 first entry", srr0, 32'h0000_7000);
        s0 = srr0;
        @(negedge clk); next_addr = 32'h0000_7777;
        edge_and_settle();
        chk("R11 entry cycle ignores", {31'h0, redirect}, 32'h0);
        chk("R11 srr0 held", srr0, s0);
        prev_srr1 = srr1;
        clear_events();
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        repeat (2) @(negedge clk);
        rst_n = 1;
        edge_and_settle();
        t_reset();
        t_fpa();
        t_fpa_disabled();
        t_tiny();
        t_prog();
        t_trace();
        t_priority();
        t_compress();
        t_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule